// File: doc/BRIEF.md
# PRBS Checker with BER Counters

This block sits on the receive side of a serial link test path and measures bit-error rate. Each valid parallel word is one symbol. The block compares the word against a pseudo-random binary sequence that it generates locally. It obtains lock on its own by loading its shift register from the incoming data, and it drops lock again when mismatches persist. While it is locked and counting is running, it adds the number of mismatching bit positions that the mask does not exclude to a saturating error counter. It also adds one to a saturating symbol counter.

Software sets the sequence order, a width code that fixes how many low bits of each word form a symbol, an unlock delay, a count mode, a symbol limit and a per-bit exclusion mask. It then issues one-cycle clear, start and stop commands. With a nonzero limit, counting ends by itself once the symbol count reaches the limit, and a done flag is raised. With a zero limit, or with count mode 3, counting runs freely. The division that turns the two counts into an error rate is left to software. Bits per symbol follow directly from the width code. The counter widths are parameters: 48 error bits and 64 symbol bits by default.

Top module: `ber_prbs_chk`

## Requirements
- R1: With the block enabled, the first valid word loads the local sequence state, and the next valid word is compared against the continuation of that state. `locked` goes high at the clock edge that takes a compare word with no mismatch in its active bits. Any other compare word reloads the state from itself. Symbols are counted only while `locked` is high.
- R2: `seq_sel` selects the sequence by its taps: 0 is x^7+x^6+1, 1 is x^9+x^5+1, 2 is x^11+x^9+1, 3 is x^23+x^18+1, and 4 or any higher code is x^31+x^28+1. Bit 0 of a word is the earliest bit of the sequence.
- R3: `width_code` 0 gives 64 active bits, 1 gives 32, and any other value gives 128. Only bits [n-1:0] are compared. Higher bits affect neither lock nor counts.
- R4: A set bit i in `err_mask` keeps a mismatch at bit i out of the error count. The mask has no effect on lock decisions.
- R5: Each valid word that arrives while the block is enabled, locked and running adds 1 to `sym_count` and adds its number of unmasked active mismatches to `err_count`.
- R6: While locked, `unlock_sel`+1 consecutive valid words that each contain any active mismatch drop `locked` at the edge of the last of them. The state is then reloaded from that word. A clean word resets the run.
- R7: `cmd_clear` sets both counts and `done` to zero and takes priority over counting in the same cycle. `cmd_stop` halts counting with the counts held. `cmd_start` resumes counting. When stop and start arrive together, stop wins.
- R8: When `cnt_mode` is not 3 and `sym_limit` is nonzero, counting stops once `sym_count` reaches `sym_limit`, and `done` rises at that same edge.
- R9: With `sym_limit` zero, or with `cnt_mode` equal to 3, there is no limit and `done` stays low.
- R10: Both counters saturate at their all-ones value instead of wrapping.
- R11: While `chk_en` is low, `locked` is low from the next edge, nothing is counted, and the next enabled valid word starts a fresh lock search.
- R12: After reset, `locked`, `done`, `err_count` and `sym_count` are all zero, and counting is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Enables the whole checker |
| seq_sel | input | 4 | Sequence order select |
| width_code | input | 3 | Active width / bits-per-symbol code |
| unlock_sel | input | DLY_W (3) | Consecutive bad words tolerated before unlock, minus one |
| cnt_mode | input | 2 | Value 3 forces free-running counting |
| sym_limit | input | SYM_W (64) | Symbol limit; zero means free running |
| err_mask | input | DATA_W (128) | Per-bit exclusion from error counting |
| cmd_start | input | 1 | One-cycle start command |
| cmd_stop | input | 1 | One-cycle stop command |
| cmd_clear | input | 1 | One-cycle clear command |
| rx_valid | input | 1 | Word on `rx_data` is valid |
| rx_data | input | DATA_W (128) | Received parallel word, bit 0 earliest |
| locked | output | 1 | Sequence lock indication |
| done | output | 1 | Symbol limit reached |
| err_count | output | ERR_W (48) | Saturating count of unmasked bit errors |
| sym_count | output | SYM_W (64) | Saturating symbol count |

## Verification
The assertions assume that commands are single-cycle pulses, and that `sym_limit` is held steady while a limited run is counting. The done check compares the count with the limit from the cycle before. The stimulus changes configuration only between runs or while the block is disabled, keeps the limit fixed across each limited run, and pulses each command for exactly one clock. Transmit data comes from a separate sequence source in the bench. Errors are injected by inverting chosen bits, so the bench never sends data that is all zeros, which would lock trivially.

// File: rtl/ber_prbs_pkg.sv
package ber_prbs_pkg;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_CHECK = 2'd1,
      ST_LOCK  = 2'd2
   } lock_state_e;

   localparam int unsigned MIN_SEED_W = 31;
   localparam int unsigned MAX_SYM_BITS = 128;

   // active bits per symbol from the width code
   function automatic logic [7:0] sym_bits(input logic [2:0] wcode);
      case (wcode)
         3'd0:    return 8'd64;
         3'd1:    return 8'd32;
         default: return 8'd128;
      endcase
   endfunction

   // index of the oldest tap (degree - 1)
   function automatic logic [4:0] tap_far(input logic [3:0] sel);
      case (sel)
         4'd0:    return 5'd6;
         4'd1:    return 5'd8;
         4'd2:    return 5'd10;
         4'd3:    return 5'd22;
         default: return 5'd30;
      endcase
   endfunction

   // index of the inner tap
   function automatic logic [4:0] tap_near(input logic [3:0] sel);
      case (sel)
         4'd0:    return 5'd5;
         4'd1:    return 5'd4;
         4'd2:    return 5'd8;
         4'd3:    return 5'd17;
         default: return 5'd27;
      endcase
   endfunction

endpackage

// File: rtl/ber_prbs_ref.sv
module ber_prbs_ref
   import ber_prbs_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int SEED_W = 31
) (
   input  logic [SEED_W-1:0] seed_q,
   input  logic [3:0]        seq_sel,
   input  logic [7:0]        nbits,
   input  logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] pred,
   output logic [SEED_W-1:0] seed_gen,
   output logic [SEED_W-1:0] seed_rx
);

   logic [4:0]        far_idx;
   logic [4:0]        near_idx;
   logic [SEED_W-1:0] g_st;
   logic [SEED_W-1:0] r_st;
   logic              nxt;

   // bit 0 of the state is the newest bit; the word is walked earliest-first
   always_comb begin
      far_idx  = tap_far(seq_sel);
      near_idx = tap_near(seq_sel);
      g_st     = seed_q;
      r_st     = seed_q;
      pred     = '0;
      nxt      = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(nbits)) begin
            nxt     = g_st[far_idx] ^ g_st[near_idx];
            pred[i] = nxt;
            g_st    = {g_st[SEED_W-2:0], nxt};
            r_st    = {r_st[SEED_W-2:0], rx_data[i]};
         end
      end
      seed_gen = g_st;
      seed_rx  = r_st;
   end

endmodule

// File: rtl/ber_lock_fsm.sv
module ber_lock_fsm
   import ber_prbs_pkg::*;
#(
   parameter int DLY_W  = 3,
   parameter int SEED_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              valid,
   input  logic              mismatch,
   input  logic [DLY_W-1:0]  dly_sel,
   input  logic [SEED_W-1:0] seed_gen,
   input  logic [SEED_W-1:0] seed_rx,
   output lock_state_e       state_q,
   output logic [SEED_W-1:0] seed_q
);

   logic [DLY_W-1:0] bad_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         bad_q   <= '0;
         seed_q  <= '0;
      end else if (!en) begin
         state_q <= ST_HUNT;
         bad_q   <= '0;
      end else if (valid) begin
         case (state_q)
            ST_HUNT: begin
               seed_q  <= seed_rx;
               state_q <= ST_CHECK;
            end
            ST_CHECK: begin
               if (!mismatch) begin
                  seed_q  <= seed_gen;
                  state_q <= ST_LOCK;
               end else begin
                  seed_q  <= seed_rx;
               end
            end
            ST_LOCK: begin
               if (mismatch) begin
                  if (bad_q >= dly_sel) begin
                     seed_q  <= seed_rx;
                     state_q <= ST_CHECK;
                     bad_q   <= '0;
                  end else begin
                     seed_q <= seed_gen;
                     bad_q  <= bad_q + 1'b1;
                  end
               end else begin
                  seed_q <= seed_gen;
                  bad_q  <= '0;
               end
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/ber_err_accum.sv
module ber_err_accum #(
   parameter int DATA_W = 128,
   parameter int ERR_W  = 48,
   parameter int SYM_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_clear,
   input  logic              word_ok,
   input  logic              lim_active,
   input  logic [SYM_W-1:0]  sym_limit,
   input  logic [DATA_W-1:0] err_vec,
   output logic [ERR_W-1:0]  err_q,
   output logic [SYM_W-1:0]  sym_q,
   output logic              done_q
);

   localparam int PC_W = $clog2(DATA_W + 1);

   logic [PC_W-1:0] pop;
   logic [ERR_W:0]  err_sum;
   logic [SYM_W:0]  sym_inc;
   logic            running_q;
   logic            at_limit;
   logic            hit;
   logic            do_cnt;

   always_comb begin
      pop = '0;
      for (int i = 0; i < DATA_W; i++) begin
         pop = pop + PC_W'(err_vec[i]);
      end
   end

   assign err_sum  = {1'b0, err_q} + {{(ERR_W + 1 - PC_W){1'b0}}, pop};
   assign sym_inc  = {1'b0, sym_q} + {{SYM_W{1'b0}}, 1'b1};
   assign at_limit = lim_active && (sym_q >= sym_limit);
   assign hit      = lim_active && (sym_inc == {1'b0, sym_limit});
   assign do_cnt   = running_q && word_ok && !at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
      end else if (cmd_stop) begin
         running_q <= 1'b0;
      end else if (cmd_start) begin
         running_q <= 1'b1;
      end else if (do_cnt && hit) begin
         running_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= '0;
         sym_q  <= '0;
         done_q <= 1'b0;
      end else if (cmd_clear) begin
         err_q  <= '0;
         sym_q  <= '0;
         done_q <= 1'b0;
      end else if (do_cnt) begin
         sym_q <= sym_inc[SYM_W] ? sym_q : sym_inc[SYM_W-1:0];
         err_q <= err_sum[ERR_W] ? {ERR_W{1'b1}} : err_sum[ERR_W-1:0];
         if (hit) begin
            done_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ber_prbs_chk.sv
module ber_prbs_chk
   import ber_prbs_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int ERR_W  = 48,
   parameter int SYM_W  = 64,
   parameter int DLY_W  = 3,
   parameter int SEED_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic [3:0]        seq_sel,
   input  logic [2:0]        width_code,
   input  logic [DLY_W-1:0]  unlock_sel,
   input  logic [1:0]        cnt_mode,
   input  logic [SYM_W-1:0]  sym_limit,
   input  logic [DATA_W-1:0] err_mask,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_clear,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              locked,
   output logic              done,
   output logic [ERR_W-1:0]  err_count,
   output logic [SYM_W-1:0]  sym_count
);

   localparam int PC_W = $clog2(DATA_W + 1);

   if (DATA_W < int'(MAX_SYM_BITS)) begin : g_chk_data_w
      $error("DATA_W must hold the widest symbol");
   end
   if (SEED_W < int'(MIN_SEED_W)) begin : g_chk_seed_w
      $error("SEED_W must hold the longest sequence state");
   end
   if (ERR_W < PC_W) begin : g_chk_err_w
      $error("ERR_W must hold one word of errors");
   end
   if (SYM_W < 2 || DLY_W < 1) begin : g_chk_misc_w
      $error("SYM_W or DLY_W too small");
   end

   logic [7:0]        nbits;
   logic [DATA_W-1:0] pred;
   logic [DATA_W-1:0] diff;
   logic [DATA_W-1:0] cnt_vec;
   logic [SEED_W-1:0] seed_q;
   logic [SEED_W-1:0] seed_gen;
   logic [SEED_W-1:0] seed_rx;
   lock_state_e       state_q;
   logic              mismatch;
   logic              word_ok;
   logic              lim_active;

   assign nbits = sym_bits(width_code);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic live;
      assign live       = (i < int'(nbits));
      assign diff[i]    = (rx_data[i] ^ pred[i]) & live;
      assign cnt_vec[i] = diff[i] & ~err_mask[i];
   end

   assign mismatch   = |diff;
   assign locked     = (state_q == ST_LOCK);
   assign word_ok    = chk_en && rx_valid && locked;
   assign lim_active = (cnt_mode != 2'd3) && (sym_limit != '0);

   ber_prbs_ref #(.DATA_W(DATA_W), .SEED_W(SEED_W)) u_ref (
      .seed_q   (seed_q),
      .seq_sel  (seq_sel),
      .nbits    (nbits),
      .rx_data  (rx_data),
      .pred     (pred),
      .seed_gen (seed_gen),
      .seed_rx  (seed_rx)
   );

   ber_lock_fsm #(.DLY_W(DLY_W), .SEED_W(SEED_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (chk_en),
      .valid    (rx_valid),
      .mismatch (mismatch),
      .dly_sel  (unlock_sel),
      .seed_gen (seed_gen),
      .seed_rx  (seed_rx),
      .state_q  (state_q),
      .seed_q   (seed_q)
   );

   ber_err_accum #(.DATA_W(DATA_W), .ERR_W(ERR_W), .SYM_W(SYM_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_start  (cmd_start),
      .cmd_stop   (cmd_stop),
      .cmd_clear  (cmd_clear),
      .word_ok    (word_ok),
      .lim_active (lim_active),
      .sym_limit  (sym_limit),
      .err_vec    (cnt_vec),
      .err_q      (err_count),
      .sym_q      (sym_count),
      .done_q     (done)
   );

endmodule

// File: rtl/ber_prbs_chk_sva.sv
module ber_prbs_chk_sva #(
   parameter int ERR_W = 48,
   parameter int SYM_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chk_en,
   input logic             cmd_clear,
   input logic [SYM_W-1:0] sym_limit,
   input logic             locked,
   input logic             done,
   input logic [ERR_W-1:0] err_count,
   input logic [SYM_W-1:0] sym_count
);

   AST_DISABLE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |=> !locked); // R11

   AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !cmd_clear) |=> $stable(sym_count) && $stable(err_count)); // R1

   AST_SYM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_clear |=> (sym_count == $past(sym_count)) || (sym_count == $past(sym_count) + 1'b1)); // R5

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_clear |=> (sym_count >= $past(sym_count)) && (err_count >= $past(err_count))); // R10

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clear |=> (sym_count == '0) && (err_count == '0) && !done); // R7

   AST_DONE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (sym_count == $past(sym_limit)) && (sym_limit != '0)); // R8

endmodule

bind ber_prbs_chk ber_prbs_chk_sva #(.ERR_W(ERR_W), .SYM_W(SYM_W)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .chk_en    (chk_en),
   .cmd_clear (cmd_clear),
   .sym_limit (sym_limit),
   .locked    (locked),
   .done      (done),
   .err_count (err_count),
   .sym_count (sym_count)
);

// File: tb/sim_ber_prbs_chk.sv
module sim_ber_prbs_chk;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 128;
   localparam int EW = 10;
   localparam int SW = 12;
   localparam longint EMAX = (longint'(1) << EW) - 1;
   localparam longint SMAX = (longint'(1) << SW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chk_en = 1'b0;
   logic [3:0]    seq_sel = 4'd0;
   logic [2:0]    width_code = 3'd0;
   logic [2:0]    unlock_sel = 3'd0;
   logic [1:0]    cnt_mode = 2'd0;
   logic [SW-1:0] sym_limit = '0;
   logic [DW-1:0] err_mask = '0;
   logic          cmd_start = 1'b0;
   logic          cmd_stop = 1'b0;
   logic          cmd_clear = 1'b0;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          locked;
   logic          done;
   logic [EW-1:0] err_count;
   logic [SW-1:0] sym_count;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ber_prbs_chk #(.ERR_W(EW), .SYM_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .seq_sel(seq_sel),
      .width_code(width_code), .unlock_sel(unlock_sel), .cnt_mode(cnt_mode),
      .sym_limit(sym_limit), .err_mask(err_mask), .cmd_start(cmd_start),
      .cmd_stop(cmd_stop), .cmd_clear(cmd_clear), .rx_valid(rx_valid),
      .rx_data(rx_data), .locked(locked), .done(done),
      .err_count(err_count), .sym_count(sym_count)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    finished = 0;
   string phase = "R12 reset";

   function automatic int bps_of(input logic [2:0] w);
      if (w == 3'd0) return 64;
      if (w == 3'd1) return 32;
      return 128;
   endfunction

   function automatic int deg_of(input logic [3:0] s);
      case (s)
         4'd0: return 7;
         4'd1: return 9;
         4'd2: return 11;
         4'd3: return 23;
         default: return 31;
      endcase
   endfunction

   function automatic int inner_of(input logic [3:0] s);
      case (s)
         4'd0: return 6;
         4'd1: return 5;
         4'd2: return 9;
         4'd3: return 18;
         default: return 28;
      endcase
   endfunction

   // ---------------- behavioural reference model ----------------
   int     m_state;   // 0 hunt, 1 check, 2 locked
   int     m_bad;
   longint m_err;
   longint m_sym;
   bit     m_run;
   bit     m_done;
   bit     m_hist[$];
   bit     mg[$];
   bit     mr[$];
   int     mn, ma, mb, mraw, mcnt;
   bit     mp, mok, mlim, mhit, mdo;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_bad = 0; m_err = 0; m_sym = 0; m_run = 0; m_done = 0;
         m_hist = {};
         repeat (31) m_hist.push_back(1'b0);
      end else begin
         mn = bps_of(width_code);
         ma = deg_of(seq_sel);
         mb = inner_of(seq_sel);
         mg = m_hist;
         mr = m_hist;
         mraw = 0;
         mcnt = 0;
         for (int i = 0; i < mn; i++) begin
            mp = mg[ma-1] ^ mg[mb-1];
            mg.push_front(mp);
            void'(mg.pop_back());
            mr.push_front(rx_data[i]);
            void'(mr.pop_back());
            if (rx_data[i] != mp) begin
               mraw++;
               if (!err_mask[i]) mcnt++;
            end
         end
         mok  = chk_en && rx_valid && (m_state == 2);
         mlim = (cnt_mode != 2'd3) && (sym_limit != 0);
         mdo  = m_run && mok && !(mlim && m_sym >= longint'(sym_limit));
         mhit = mlim && (m_sym + 1 == longint'(sym_limit));
         if (cmd_stop) m_run = 0;
         else if (cmd_start) m_run = 1;
         else if (mdo && mhit) m_run = 0;
         if (cmd_clear) begin
            m_err = 0; m_sym = 0; m_done = 0;
         end else if (mdo) begin
            if (m_sym < SMAX) m_sym++;
            m_err += mcnt;
            if (m_err > EMAX) m_err = EMAX;
            if (mhit) m_done = 1;
         end
         if (!chk_en) begin
            m_state = 0; m_bad = 0;
         end else if (rx_valid) begin
            if (m_state == 0) begin
               m_hist = mr; m_state = 1;
            end else if (m_state == 1) begin
               if (mraw == 0) begin m_state = 2; m_hist = mg; end
               else m_hist = mr;
            end else begin
               if (mraw != 0) begin
                  if (m_bad >= int'(unlock_sel)) begin
                     m_state = 1; m_hist = mr; m_bad = 0;
                  end else begin
                     m_bad++; m_hist = mg;
                  end
               end else begin
                  m_bad = 0; m_hist = mg;
               end
            end
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit bad;
         bad = 0;
         n_cmp++;
         if (locked !== (m_state == 2)) begin
            bad = 1;
            $display("FAIL R1/R6/R11 locked [%s] actual=%0b expected=%0b", phase, locked, m_state == 2);
         end
         if (done !== m_done) begin
            bad = 1;
            $display("FAIL R8/R9 done [%s] actual=%0b expected=%0b", phase, done, m_done);
         end
         if (longint'(err_count) != m_err) begin
            bad = 1;
            $display("FAIL R5/R4 err_count [%s] actual=%0d expected=%0d", phase, err_count, m_err);
         end
         if (longint'(sym_count) != m_sym) begin
            bad = 1;
            $display("FAIL R5/R7 sym_count [%s] actual=%0d expected=%0d", phase, sym_count, m_sym);
         end
         if (bad) n_bad++;
      end
   end

   // ---------------- transmit side ----------------
   bit tx_q[$];

   task automatic make_word(output logic [DW-1:0] w);
      int n, a, b;
      bit p;
      n = bps_of(width_code);
      a = deg_of(seq_sel);
      b = inner_of(seq_sel);
      for (int i = 0; i < DW; i++) begin
         if (i < n) begin
            p = tx_q[a-1] ^ tx_q[b-1];
            tx_q.push_front(p);
            void'(tx_q.pop_back());
            w[i] = p;
         end else begin
            w[i] = (i % 3 == 0);
         end
      end
   endtask

   task automatic send(input int f1, input int f2, input bit inv);
      logic [DW-1:0] w;
      make_word(w);
      if (inv) begin
         for (int i = 0; i < bps_of(width_code); i++) w[i] = ~w[i];
      end
      if (f1 >= 0) w[f1] = ~w[f1];
      if (f2 >= 0) w[f2] = ~w[f2];
      @(negedge clk);
      cmd_start = 0; cmd_stop = 0; cmd_clear = 0;
      rx_valid = 1;
      rx_data = w;
   endtask

   task automatic clean(input int k);
      for (int j = 0; j < k; j++) send(-1, -1, 1'b0);
   endtask

   task automatic cmd(input bit s, input bit t, input bit c);
      @(negedge clk);
      rx_valid = 0;
      cmd_start = s; cmd_stop = t; cmd_clear = c;
   endtask

   task automatic idle();
      @(negedge clk);
      rx_valid = 0;
      cmd_start = 0; cmd_stop = 0; cmd_clear = 0;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (31) tx_q.push_back(1'b1);
      repeat (3) @(negedge clk);
      // R12: outputs at reset
      n_cmp++;
      if (locked !== 1'b0 || done !== 1'b0 || err_count !== '0 || sym_count !== '0) begin
         n_bad++;
         $display("FAIL R12 reset: actual=%0b/%0b/%0d/%0d expected=0/0/0/0",
                  locked, done, err_count, sym_count);
      end
      rst_n = 1;
      chk_en = 1;
      idle();
      cmd(0, 0, 1);
      cmd(1, 0, 0);

      phase = "R1 R5 lock and count PRBS7 w64";
      clean(20);

      phase = "R4 R5 masked errors";
      unlock_sel = 3'd3;
      err_mask = 128'hFF;
      for (int j = 0; j < 6; j++) begin
         send(3, 20, 1'b0);
         send(5, -1, 1'b0);
         clean(1);
      end

      phase = "R6 unlock after run";
      err_mask = '0;
      unlock_sel = 3'd1;
      send(10, -1, 1'b0);
      clean(1);
      send(11, -1, 1'b0);
      send(12, -1, 1'b0);
      clean(8);

      phase = "R3 width 32 upper bits ignored";
      width_code = 3'd1;
      clean(4);
      send(40, 100, 1'b0);
      clean(10);

      phase = "R3 width 128";
      width_code = 3'd6;
      clean(4);
      send(127, -1, 1'b0);
      clean(8);

      phase = "R2 orders";
      width_code = 3'd0;
      for (int s = 1; s < 6; s++) begin
         chk_en = 0;
         idle();
         seq_sel = (s == 5) ? 4'd9 : 4'(s);
         chk_en = 1;
         clean(12);
         send(7, -1, 1'b0);
         clean(3);
      end
      chk_en = 0;
      idle();
      seq_sel = 4'd0;
      chk_en = 1;
      clean(6);

      phase = "R7 stop clear start";
      cmd(0, 1, 0);
      clean(5);
      cmd(1, 1, 0);
      clean(3);
      cmd(0, 0, 1);
      clean(2);
      cmd(1, 0, 0);
      clean(5);

      phase = "R8 symbol limit";
      sym_limit = 12'd15;
      cnt_mode = 2'd0;
      cmd(0, 0, 1);
      cmd(1, 0, 0);
      clean(25);
      cmd(1, 0, 0);
      clean(3);

      phase = "R9 count mode 3 free run";
      cnt_mode = 2'd3;
      cmd(0, 0, 1);
      cmd(1, 0, 0);
      clean(25);
      phase = "R9 zero limit free run";
      cnt_mode = 2'd0;
      sym_limit = '0;
      cmd(0, 0, 1);
      cmd(1, 0, 0);
      clean(20);

      phase = "R11 enable low";
      chk_en = 0;
      send(4, -1, 1'b0);
      clean(4);
      chk_en = 1;
      clean(8);

      phase = "R10 error saturation";
      width_code = 3'd6;
      unlock_sel = 3'd7;
      cmd(0, 0, 1);
      cmd(1, 0, 0);
      clean(4);
      for (int k = 0; k < 2; k++) begin
         for (int j = 0; j < 7; j++) send(-1, -1, 1'b1);
         clean(1);
      end
      clean(2);

      phase = "R10 symbol saturation";
      cnt_mode = 2'd3;
      width_code = 3'd1;
      cmd(0, 0, 1);
      cmd(1, 0, 0);
      clean(6);
      clean(int'(SMAX) + 10);
      idle();
      idle();
      finish_run();
   end

endmodule